// File: doc/BRIEF.md
# Stop-Mode Entry, Release and Oscillator Warm-Up Controller

This block decides when a low-power stop state is entered, what ends it, and how long the oscillator is given to settle before the system clock is handed back. A one-cycle stop request puts the block into stop. While it is in stop, the oscillator-off output is high, and the general port output enables are either held or dropped according to an output-hold select. The enable for the stop pin's own port is always dropped. Release comes from the stop pin, from a set of active-low key-wakeup inputs that each have their own enable, or from an external reset request. Release is followed by a warm-up count whose length depends on a two-bit code and on the mode being returned to. When the count ends, a one-cycle done strobe is raised together with the return mode.

Two release styles are supported. In level style, a wake condition that is present ends stop, and a request made while a wake condition is already present skips stop altogether and goes straight to warm-up. In edge style, stop is always entered, and only a rising edge on the stop pin ends it. A switch from edge style to level style does not take effect until the next rising edge of the stop pin. The stop pin and the key inputs pass through two-flop synchronisers. The warm-up exponents are parameters, so the periods can be scaled down.

Top module: `stop_wake_ctrl`

## Requirements
- R1: In level style (rel_edge=0 in effect) the block leaves stop for warm-up when the synchronised stop pin is 1 or any key_n bit whose key_en bit is 1 is 0. A low key_n bit whose enable is 0 has no effect.
- R2: In level style, a stop_req that arrives while a wake condition holds never raises osc_off. warm_busy rises at the next clock edge.
- R3: In edge style (rel_edge=1), stop_req always enters stop, even with the stop pin high. Key inputs and a stop pin held high or low do not end stop. Only a 0-to-1 change of the synchronised stop pin does.
- R4: Setting rel_edge from 1 to 0 leaves edge style in force until the synchronised stop pin next rises. Setting rel_edge to 1 takes effect at once.
- R5: When returning to normal (ret_slow=0 at the request), warm_busy lasts 3*2^NORM_EXP_HI, 2^NORM_EXP_HI, 3*2^NORM_EXP_LO and 2^NORM_EXP_LO cycles for wu_sel 00, 01, 10 and 11.
- R6: When returning to slow (ret_slow=1), the lengths are 3*2^SLOW_EXP_HI, 2^SLOW_EXP_HI, 3*2^SLOW_EXP_LO and 2^SLOW_EXP_LO cycles for the same codes.
- R7: done is high for exactly one cycle, the cycle right after the last warm_busy cycle. done_mode is 0 for a normal return and 1 for a slow return.
- R8: pin_reset high during stop or warm-up starts, or restarts, a warm-up with the normal length for the latched wu_sel. done_mode is then 2 (normal-1).
- R9: Once warm-up has begun, a fall of the stop pin and a new stop_req do not bring back stop. stop_req is ignored outside the run state.
- R10: During stop, port_oe equals hold_out as sampled at the request, and stoppin_oe is 0. Outside stop both are 1.
- R11: A change on the stop pin or a key input reaches the state machine through two synchroniser flops. warm_busy changes on the third rising edge after the input changes.
- R12: After reset, osc_off, warm_busy and done are 0, port_oe and stoppin_oe are 1, done_mode is 0, and level style is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock that also times the warm-up |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle request to enter stop |
| stop_pin | input | 1 | Asynchronous stop-release pin |
| key_n | input | KEYS | Asynchronous active-low key-wakeup inputs |
| key_en | input | KEYS | Per-key wakeup enable |
| rel_edge | input | 1 | Release style: 1 edge, 0 level |
| ret_slow | input | 1 | Return mode: 1 slow, 0 normal |
| wu_sel | input | 2 | Warm-up length code |
| hold_out | input | 1 | 1 keeps port outputs driven during stop |
| pin_reset | input | 1 | External reset request that forces a normal-1 return |
| osc_off | output | 1 | Oscillator stop command |
| warm_busy | output | 1 | Warm-up count in progress |
| done | output | 1 | One-cycle strobe at the end of warm-up |
| done_mode | output | 2 | 0 normal, 1 slow, 2 normal-1 after reset |
| port_oe | output | 1 | General port output enable gating |
| stoppin_oe | output | 1 | Output enable of the stop pin's port |

## Verification
The hardest situation to reach is pending edge style: rel_edge already reads 0 but edge style is still in force, so a stop request made with the stop pin high must still enter stop. The stimulus reaches it by entering edge style, raising the stop pin and letting it settle through the synchronisers, then clearing rel_edge while the pin stays high. The next request must then enter stop, and a later rising edge both ends stop and switches the block to level style. A second request made with the pin still high checks that stop is then skipped. A behavioural reference model runs alongside on every clock to check timing through the synchronisers and pin_reset restarts in the middle of a warm-up.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2
    } swk_state_e;

    typedef enum logic [1:0] {
        RET_NORMAL  = 2'd0,
        RET_SLOW    = 2'd1,
        RET_NORMAL1 = 2'd2
    } swk_ret_e;

    typedef struct packed {
        logic       slow;
        logic [1:0] sel;
        logic       hold;
    } swk_cfg_t;

    // Warm-up length in cycles: sel[1] picks the low exponent,
    // sel[0]=0 multiplies by three.
    function automatic logic [31:0] warm_cycles(
        input logic       slow,
        input logic [1:0] sel,
        input int         nh,
        input int         nl,
        input int         sh,
        input int         sl
    );
        int exp_v;
        if (slow) exp_v = sel[1] ? sl : sh;
        else      exp_v = sel[1] ? nl : nh;
        warm_cycles = (32'd1 << exp_v) * (sel[0] ? 32'd1 : 32'd3);
    endfunction

endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/swk_wake_det.sv
module swk_wake_det #(
    parameter int KEYS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pin_s,
    input  logic [KEYS-1:0] key_s,
    input  logic [KEYS-1:0] key_en,
    input  logic            rel_edge,
    output logic            wake_lvl,
    output logic            pin_rise,
    output logic            edge_mode
);
    logic            pin_prev;
    logic [KEYS-1:0] key_hit;

    for (genvar i = 0; i < KEYS; i++) begin : g_key
        assign key_hit[i] = key_en[i] & ~key_s[i];
    end

    assign wake_lvl = pin_s | (|key_hit);
    assign pin_rise = pin_s & ~pin_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev  <= 1'b0;
            edge_mode <= 1'b0;
        end else begin
            pin_prev <= pin_s;
            if (rel_edge)      edge_mode <= 1'b1;
            else if (pin_rise) edge_mode <= 1'b0;
        end
    end

    // R4: leaving edge style needs a rising edge of the pin
    a_r4_edge_holds: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && !pin_rise) |=> edge_mode);
    // R4: entering edge style is immediate
    a_r4_edge_enter: assert property (@(posedge clk) disable iff (rst)
        rel_edge |=> edge_mode);
endmodule

// File: rtl/swk_warm_timer.sv
module swk_warm_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5: the count steps down by exactly one per cycle
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        (!load && dec && !zero) |=> (cnt == $past(cnt) - 1'b1));
    // R5: a load takes the programmed value
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swk_pkg::*;
#(
    parameter int KEYS        = 4,
    parameter int NORM_EXP_HI = 16,
    parameter int NORM_EXP_LO = 14,
    parameter int SLOW_EXP_HI = 13,
    parameter int SLOW_EXP_LO = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_req,
    input  logic            stop_pin,
    input  logic [KEYS-1:0] key_n,
    input  logic [KEYS-1:0] key_en,
    input  logic            rel_edge,
    input  logic            ret_slow,
    input  logic [1:0]      wu_sel,
    input  logic            hold_out,
    input  logic            pin_reset,
    output logic            osc_off,
    output logic            warm_busy,
    output logic            done,
    output logic [1:0]      done_mode,
    output logic            port_oe,
    output logic            stoppin_oe
);
    localparam int EMAX = (NORM_EXP_HI > SLOW_EXP_HI) ? NORM_EXP_HI : SLOW_EXP_HI;
    localparam int CW   = EMAX + 2;

    logic            pin_s;
    logic [KEYS-1:0] key_s;
    logic            wake_lvl, pin_rise, edge_mode;

    swk_sync #(.W(1), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst(rst), .d(stop_pin), .q(pin_s));

    swk_sync #(.W(KEYS), .RST_VAL({KEYS{1'b1}})) u_key_sync (
        .clk(clk), .rst(rst), .d(key_n), .q(key_s));

    swk_wake_det #(.KEYS(KEYS)) u_det (
        .clk(clk), .rst(rst), .pin_s(pin_s), .key_s(key_s), .key_en(key_en),
        .rel_edge(rel_edge), .wake_lvl(wake_lvl), .pin_rise(pin_rise),
        .edge_mode(edge_mode));

    swk_state_e st_q, st_d;
    swk_ret_e   ret_q, ret_d;
    swk_cfg_t   cfg_q, cfg_d;
    logic       done_q, done_d;

    logic          t_load, t_dec, t_zero;
    logic [CW-1:0] t_val;
    logic [31:0]   len_req, len_cur, len_norm;

    assign len_req  = warm_cycles(ret_slow, wu_sel,
                                  NORM_EXP_HI, NORM_EXP_LO, SLOW_EXP_HI, SLOW_EXP_LO);
    assign len_cur  = warm_cycles(cfg_q.slow, cfg_q.sel,
                                  NORM_EXP_HI, NORM_EXP_LO, SLOW_EXP_HI, SLOW_EXP_LO);
    assign len_norm = warm_cycles(1'b0, cfg_q.sel,
                                  NORM_EXP_HI, NORM_EXP_LO, SLOW_EXP_HI, SLOW_EXP_LO);

    logic [31:0] req_m1, cur_m1, norm_m1;
    assign req_m1  = len_req  - 32'd1;
    assign cur_m1  = len_cur  - 32'd1;
    assign norm_m1 = len_norm - 32'd1;

    always_comb begin
        st_d   = st_q;
        ret_d  = ret_q;
        cfg_d  = cfg_q;
        done_d = 1'b0;
        t_load = 1'b0;
        t_dec  = 1'b0;
        t_val  = '0;
        unique case (st_q)
            ST_RUN: begin
                if (stop_req) begin
                    cfg_d.slow = ret_slow;
                    cfg_d.sel  = wu_sel;
                    cfg_d.hold = hold_out;
                    ret_d      = ret_slow ? RET_SLOW : RET_NORMAL;
                    if (!edge_mode && wake_lvl) begin
                        st_d   = ST_WARM;
                        t_load = 1'b1;
                        t_val  = req_m1[CW-1:0];
                    end else begin
                        st_d   = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (pin_reset) begin
                    st_d   = ST_WARM;
                    ret_d  = RET_NORMAL1;
                    t_load = 1'b1;
                    t_val  = norm_m1[CW-1:0];
                end else if (edge_mode ? pin_rise : wake_lvl) begin
                    st_d   = ST_WARM;
                    t_load = 1'b1;
                    t_val  = cur_m1[CW-1:0];
                end
            end
            ST_WARM: begin
                if (pin_reset) begin
                    ret_d  = RET_NORMAL1;
                    t_load = 1'b1;
                    t_val  = norm_m1[CW-1:0];
                end else if (t_zero) begin
                    st_d   = ST_RUN;
                    done_d = 1'b1;
                end else begin
                    t_dec  = 1'b1;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    swk_warm_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
        .dec(t_dec), .zero(t_zero));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            ret_q  <= RET_NORMAL;
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ret_q  <= ret_d;
            cfg_q  <= cfg_d;
            done_q <= done_d;
        end
    end

    assign osc_off    = (st_q == ST_STOP);
    assign warm_busy  = (st_q == ST_WARM);
    assign done       = done_q;
    assign done_mode  = ret_q;
    assign stoppin_oe = (st_q != ST_STOP);
    assign port_oe    = (st_q != ST_STOP) | cfg_q.hold;

    // R1: a level-style wake condition in stop moves on to warm-up
    a_r1_level_release: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP && !edge_mode && wake_lvl) |=> (st_q == ST_WARM));
    // R2: a request made while a wake condition holds skips stop
    a_r2_skip_stop: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && stop_req && !edge_mode && wake_lvl) |=> (st_q == ST_WARM));
    // R3: in edge style only a pin rise or reset ends stop
    a_r3_edge_stays: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP && edge_mode && !pin_rise && !pin_reset) |=> (st_q == ST_STOP));
    // R9: warm-up never falls back into stop
    a_r9_no_reentry: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WARM) |=> (st_q != ST_STOP));
    // R7: done only follows a warm-up cycle
    a_r7_done_after_warm: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(st_q) == ST_WARM));
    // R8: an external reset in stop or warm-up gives a normal-1 warm-up
    a_r8_reset_restart: assert property (@(posedge clk) disable iff (rst)
        ((st_q != ST_RUN) && pin_reset) |=> (st_q == ST_WARM && ret_q == RET_NORMAL1));
    // R10: the output-hold choice is stable through stop
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STOP && $past(st_q) == ST_STOP) |-> $stable(port_oe));
endmodule

// File: tb/tb_stop_wake_ctrl.sv
`timescale 1ns/1ps
module tb_stop_wake_ctrl;
    localparam int KEYS = 4;
    localparam int NH = 6, NL = 4, SH = 5, SL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 0, stop_pin = 0, rel_edge = 0, ret_slow = 0, hold_out = 0, pin_reset = 0;
    logic [KEYS-1:0] key_n = '1, key_en = '0;
    logic [1:0] wu_sel = 2'd0;
    logic osc_off, warm_busy, done, port_oe, stoppin_oe;
    logic [1:0] done_mode;

    int checks = 0, failures = 0, cycles = 0;

    always #4 clk = ~clk;

    stop_wake_ctrl #(.KEYS(KEYS), .NORM_EXP_HI(NH), .NORM_EXP_LO(NL),
                     .SLOW_EXP_HI(SH), .SLOW_EXP_LO(SL)) dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .stop_pin(stop_pin),
        .key_n(key_n), .key_en(key_en), .rel_edge(rel_edge), .ret_slow(ret_slow),
        .wu_sel(wu_sel), .hold_out(hold_out), .pin_reset(pin_reset),
        .osc_off(osc_off), .warm_busy(warm_busy), .done(done), .done_mode(done_mode),
        .port_oe(port_oe), .stoppin_oe(stoppin_oe));

    function automatic int ref_len(input bit slow, input bit [1:0] code);
        int tbl[4];
        if (slow) tbl = '{3 * (1 << SH), 1 << SH, 3 * (1 << SL), 1 << SL};
        else      tbl = '{3 * (1 << NH), 1 << NH, 3 * (1 << NL), 1 << NL};
        return tbl[code];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Behavioural reference model, phase: 0 run, 1 stop, 2 warm
    bit p1, p2, pold, edge_sty;
    bit [KEYS-1:0] k1, k2;
    int phase, remain, mret;
    bit m_slow, m_hold, m_done;
    bit [1:0] m_sel;

    always @(posedge clk) begin
        if (rst) begin
            p1 = 0; p2 = 0; pold = 0; k1 = '1; k2 = '1; edge_sty = 0;
            phase = 0; remain = 0; mret = 0; m_slow = 0; m_sel = 0; m_hold = 0; m_done = 0;
        end else begin
            bit wake, rise;
            wake = p2 || ((~k2 & key_en) != 0);
            rise = p2 && !pold;
            m_done = 0;
            if (phase == 0) begin
                if (stop_req) begin
                    m_slow = ret_slow; m_sel = wu_sel; m_hold = hold_out;
                    mret = ret_slow ? 1 : 0;
                    if (!edge_sty && wake) begin
                        phase = 2; remain = ref_len(ret_slow, wu_sel);
                    end else phase = 1;
                end
            end else if (phase == 1) begin
                if (pin_reset) begin
                    phase = 2; mret = 2; remain = ref_len(0, m_sel);
                end else if (edge_sty ? rise : wake) begin
                    phase = 2; remain = ref_len(m_slow, m_sel);
                end
            end else begin
                if (pin_reset) begin
                    mret = 2; remain = ref_len(0, m_sel);
                end else begin
                    remain--;
                    if (remain == 0) begin phase = 0; m_done = 1; end
                end
            end
            if (rel_edge) edge_sty = 1; else if (rise) edge_sty = 0;
            pold = p2; p2 = p1; p1 = stop_pin;
            k2 = k1; k1 = key_n;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R1 osc_off vs model", osc_off, phase == 1);
            check("R5 warm_busy vs model", warm_busy, phase == 2);
            check("R7 done vs model", done, m_done);
            check("R8 done_mode vs model", done_mode, mret);
            check("R10 port_oe vs model", port_oe, (phase != 1) || m_hold);
            check("R10 stoppin_oe vs model", stoppin_oe, phase != 1);
        end
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request();
        stop_req = 1; step(1); stop_req = 0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (warm_busy === 1'b1 && n < 1000) begin n++; step(1); end
    endtask

    initial begin
        int n;
        step(3);
        rst = 0;
        step(1);
        // R12 reset values
        check("R12 osc_off", osc_off, 0);
        check("R12 warm_busy", warm_busy, 0);
        check("R12 done", done, 0);
        check("R12 port_oe", port_oe, 1);
        check("R12 stoppin_oe", stoppin_oe, 1);
        check("R12 done_mode", done_mode, 0);

        // Level style, key wake, normal code 11
        key_en = 4'b0010; wu_sel = 2'd3; ret_slow = 0; hold_out = 0;
        request(); step(5);
        check("R1 in stop", osc_off, 1);
        check("R10 port_oe dropped", port_oe, 0);
        check("R10 stoppin_oe dropped", stoppin_oe, 0);
        key_n[0] = 0; step(6);
        check("R1 disabled key ignored", osc_off, 1);
        key_n[0] = 1; key_n[1] = 0; step(2);
        check("R11 no wake after two edges", warm_busy, 0);
        step(1);
        check("R11 wake on third edge", warm_busy, 1);
        measure(n);
        check("R5 normal code 11 length", n, 1 << NL);
        check("R7 done strobe", done, 1);
        check("R7 done_mode normal", done_mode, 0);
        step(1);
        check("R7 done single cycle", done, 0);
        key_n = '1; step(4);

        // R2: wake present at request, slow code 10
        stop_pin = 1; step(4);
        wu_sel = 2'd2; ret_slow = 1; request();
        check("R2 no stop", osc_off, 0);
        check("R2 warm at once", warm_busy, 1);
        measure(n);
        check("R6 slow code 10 length", n, 3 * (1 << SL));
        check("R7 done_mode slow", done_mode, 1);
        stop_pin = 0; step(4);

        // R3: edge style, pin high at request, hold outputs
        rel_edge = 1; stop_pin = 1; step(4);
        wu_sel = 2'd1; ret_slow = 0; hold_out = 1; request(); step(2);
        check("R3 stop entered with pin high", osc_off, 1);
        check("R10 port_oe held", port_oe, 1);
        key_en = '1; key_n = '0; step(8);
        check("R3 keys ignored", osc_off, 1);
        key_n = '1; key_en = '0; stop_pin = 0; step(4);
        check("R3 pin fall ignored", osc_off, 1);
        stop_pin = 1; step(2);
        check("R3 no release yet", warm_busy, 0);
        step(1);
        check("R3 rise releases", warm_busy, 1);
        measure(n);
        check("R5 normal code 01 length", n, 1 << NH);

        // R4: switch to level with pin high, still edge until next rise
        rel_edge = 0; hold_out = 0; step(4);
        wu_sel = 2'd3; ret_slow = 1; request(); step(2);
        check("R4 edge style still in force", osc_off, 1);
        stop_pin = 0; step(4);
        check("R4 stays in stop", osc_off, 1);
        stop_pin = 1; step(3);
        check("R4 rise releases", warm_busy, 1);
        measure(n);
        check("R6 slow code 11 length", n, 1 << SL);
        step(2);
        request();
        check("R4 level now in force", osc_off, 0);
        check("R4 level skips stop", warm_busy, 1);
        measure(n);
        stop_pin = 0; step(4);

        // R8: external reset in stop
        wu_sel = 2'd0; ret_slow = 1; request(); step(2);
        check("R8 in stop", osc_off, 1);
        pin_reset = 1; step(1); pin_reset = 0;
        check("R8 warm after reset", warm_busy, 1);
        measure(n);
        check("R8 normal length after reset", n, 3 * (1 << NH));
        check("R8 done_mode normal1", done_mode, 2);

        // R9 and R8 during warm-up
        wu_sel = 2'd1; ret_slow = 1; request(); step(2);
        stop_pin = 1; step(3);
        check("R9 warm started", warm_busy, 1);
        stop_pin = 0; stop_req = 1; step(1); stop_req = 0; step(4);
        check("R9 no stop re-entry", osc_off, 0);
        check("R9 warm continues", warm_busy, 1);
        pin_reset = 1; step(1); pin_reset = 0;
        measure(n);
        check("R8 restart in warm-up", n, 1 << NH);
        check("R8 done_mode after restart", done_mode, 2);
        step(6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule